// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of subroutine calls and interrupt entries in a small on-chip stack of its own, apart from program and data memory. Whatever decodes instructions raises a push strobe with the address to save when a call is made or an interrupt branches to its vector. It raises a pop strobe when a return-type instruction finishes a routine. During the pop cycle the block presents the saved address on its output, combinationally.

The stack is a ring of eight 13-bit slots indexed by a hidden 3-bit pointer. Nothing outside can read or load that pointer. The block never reports full, empty, overflow or underflow. Extra pushes quietly overwrite the oldest entries. Extra pops step the pointer backwards around the ring and return whatever the slot they land on holds.

Top module: `ret_ring_stack`

## Requirements
- R1: A pushed 13-bit address is returned by the matching later pop, in last-in first-out order, for up to eight nested entries.
- R2: A push alone (push_i=1, pop_i=0) writes push_addr_i into the slot at the pointer and then advances the pointer by one, modulo 8.
- R3: A pop alone (pop_i=1, push_i=0) moves the pointer back by one, modulo 8. pop_addr_o shows the slot at (pointer - 1) mod 8 in the same cycle that pop_i is high.
- R4: The ninth push since the stack was empty overwrites the first entry and the tenth overwrites the second. After ten pushes, eight pops return the 10th, 9th, ... 3rd pushed values in that order.
- R5: A pop with no unmatched push is not an error. It wraps the pointer (0 goes to 7) and returns the content of the selected slot.
- R6: A synchronous active-low reset returns the pointer to slot 0. It leaves stored entries untouched, and a push held during reset stores nothing.
- R7: With push_i and pop_i both high, pop_addr_o returns the current top entry. The push value then replaces that top slot, and the pointer does not move.
- R8: A cycle with neither strobe changes neither the pointer nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Save push_addr_i on the stack this cycle |
| push_addr_i | input | 13 | Return address to save |
| pop_i | input | 1 | Remove the top entry this cycle |
| pop_addr_o | output | 13 | Top entry, valid while pop_i is high |

## Verification
The hardest state to reach from the ports is a pointer that has lapped the ring several times in both directions. In that state the slot a pop selects depends on pushes that happened long ago and have since been partly overwritten. The stimulus pushes ten values in a row to force the overwrite, then pops past the live entries to make the pointer wrap backwards. It also applies a reset after a wrap while push is held high, so that the one slot a pop reaches after reset holds a value known from before the reset. A bench-side ring model tracks which slots hold known values, and the bench compares only those.

// File: rtl/rstk_pkg.sv
// Package: shared operation encoding for the return stack.
// Assumes: the stack depth is a power of two, so pointer arithmetic wraps naturally.
package rstk_pkg;

    typedef enum logic [1:0] {
        STK_IDLE = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10,
        STK_SWAP = 2'b11
    } stk_op_e;

    // Combine the two strobes into one operation code.
    function automatic stk_op_e classify(input logic push, input logic pop);
        return stk_op_e'({pop, push});
    endfunction

endpackage

// File: rtl/rstk_ptr.sv
// Module: rstk_ptr
// Keeps the hidden ring pointer and derives the write and read slot indices.
// Assumes: DEPTH is a power of two; push during reset is suppressed here.
module rstk_ptr #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             wr_en_o,
    output logic [PTR_W-1:0] wr_idx_o,
    output logic [PTR_W-1:0] rd_idx_o
);
    import rstk_pkg::*;

    stk_op_e          op;
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dec;
    logic [PTR_W-1:0] ptr_inc;
    logic             armed_q;

    // Decode the strobes and form the neighbouring pointer values.
    always_comb begin
        op      = classify(push_i, pop_i);
        ptr_dec = ptr_q - PTR_W'(1);
        ptr_inc = ptr_q + PTR_W'(1);
    end

    // Pointer register: advance on push, retreat on pop, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            case (op)
                STK_PUSH: ptr_q <= ptr_inc;
                STK_POP:  ptr_q <= ptr_dec;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    // Slot selection: a swap rewrites the top slot, a push writes the free slot.
    always_comb begin
        wr_en_o  = push_i && rst_n;
        wr_idx_o = (op == STK_SWAP) ? ptr_dec : ptr_q;
        rd_idx_o = ptr_dec;
    end

    // Marks cycles whose previous cycle was out of reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_push_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(push_i && !pop_i)) |-> ptr_q == PTR_W'($past(ptr_q) + 1'b1));

    assert_pop_retreat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(pop_i && !push_i)) |-> ptr_q == PTR_W'($past(ptr_q) - 1'b1));

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(push_i == pop_i)) |-> $stable(ptr_q));

    assert_reset_ptr_R6: assert property (@(posedge clk)
        !rst_n |=> ptr_q == '0);

    assert_no_write_in_reset_R6: assert property (@(posedge clk)
        !rst_n |-> !wr_en_o);

endmodule

// File: rtl/rstk_store.sv
// Module: rstk_store
// The ring of address slots: one write port, one combinational read port.
// Assumes: entries are never reset; rst_n is used only to qualify checks.
module rstk_store #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 13,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [PTR_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic [PTR_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_data_o
);
    logic [ADDR_W-1:0] slot_q [DEPTH];
    logic              armed_q;

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Slot register: load when selected by the write port.
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_idx_i == PTR_W'(s))) slot_q[s] <= wr_data_i;
        end
    end

    // Read port: the slot chosen by the pointer logic.
    always_comb rd_data_o = slot_q[rd_idx_i];

    // History qualifier for the write check.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_slot_written_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(wr_en_i)) |-> slot_q[$past(wr_idx_i)] == $past(wr_data_i));

endmodule

// File: rtl/ret_ring_stack.sv
// Module: ret_ring_stack (top)
// Eight-deep circular return-address stack with no status flags.
// Assumes: the caller strobes push on call/interrupt entry and pop on return.
module ret_ring_stack #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = 13,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [ADDR_W-1:0] push_addr_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] pop_addr_o
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_idx;
    logic [PTR_W-1:0] rd_idx;
    logic             armed_q;

    rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .pop_i    (pop_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx)
    );

    rstk_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_addr_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (pop_addr_o)
    );

    // History qualifier for the port-level checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_swap_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(push_i && pop_i)) |-> pop_addr_o == $past(push_addr_i));

    assert_push_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(push_i && !pop_i)) |-> pop_addr_o == $past(push_addr_i));

    assert_idle_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(!push_i && !pop_i)) |-> $stable(pop_addr_o));

endmodule

// File: tb/tb_ret_ring_stack.sv
module tb_ret_ring_stack;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [AW-1:0] push_addr_i = '0;
    logic          pop_i = 1'b0;
    logic [AW-1:0] pop_addr_o;

    ret_ring_stack dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i),
        .push_addr_i(push_addr_i), .pop_i(pop_i), .pop_addr_o(pop_addr_o)
    );

    always #10 clk = ~clk;

    // Ring model built from the requirements.
    logic [AW-1:0] mdl [8];
    bit            known [8];
    int            mptr = 0;

    // Scoreboard queues.
    logic [AW-1:0] exp_q [$];
    bit            chk_q [$];
    string         tag_q [$];

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic step(input bit ps, input bit pp, input logic [AW-1:0] a, input string tag);
        int idx;
        @(posedge clk); #1;
        push_i = ps; pop_i = pp; push_addr_i = a;
        idx = (mptr + 7) % 8;
        if (pp) begin
            exp_q.push_back(mdl[idx]);
            chk_q.push_back(known[idx]);
            tag_q.push_back(tag);
        end
        if (ps && pp) begin
            mdl[idx] = a; known[idx] = 1;
        end else if (ps) begin
            mdl[mptr] = a; known[mptr] = 1; mptr = (mptr + 1) % 8;
        end else if (pp) begin
            mptr = idx;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, '0, "");
    endtask

    // Reset with push held high: nothing may be stored (R6).
    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0; pop_i = 1'b0; push_i = 1'b1; push_addr_i = 13'h1ABC;
        @(posedge clk); #1;
        rst_n = 1'b1; push_i = 1'b0;
        mptr = 0;
    endtask

    // Monitor: compare each pop result in its own cycle.
    always @(negedge clk) begin
        if (rst_n && pop_i && exp_q.size() > 0) begin
            logic [AW-1:0] e;
            bit c;
            string t;
            e = exp_q.pop_front(); c = chk_q.pop_front(); t = tag_q.pop_front();
            if (c) begin
                n_checks++;
                if (pop_addr_o !== e) begin
                    n_fail++;
                    $display("FAIL %s: pop_addr_o=%h expected=%h", t, pop_addr_o, e);
                end
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) known[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1, R3: single push then pop.
        step(1, 0, 13'h0123, "R1");
        step(0, 1, '0, "R3");
        // R1: three nested, LIFO order.
        step(1, 0, 13'h0A01, "R1");
        step(1, 0, 13'h0A02, "R1");
        step(1, 0, 13'h1FFF, "R1");
        step(0, 1, '0, "R1");
        step(0, 1, '0, "R1");
        step(0, 1, '0, "R1");
        // R4: ten pushes, eight pops return 10th down to 3rd.
        for (int i = 1; i <= 10; i++) step(1, 0, AW'(13'h0400 + i), "R4");
        for (int i = 0; i < 8; i++) step(0, 1, '0, "R4");
        // R5: popping beyond the live entries wraps around the ring.
        step(0, 1, '0, "R5");
        step(0, 1, '0, "R5");
        step(0, 1, '0, "R5");
        // R7: combined push and pop replaces the top, pointer still.
        step(1, 0, 13'h0111, "R7");
        step(1, 0, 13'h0222, "R7");
        step(1, 1, 13'h0333, "R7");
        step(0, 1, '0, "R7");
        step(0, 1, '0, "R7");
        // R8: idle cycles leave pointer and entries alone.
        step(1, 0, 13'h1555, "R8");
        idle(5);
        step(0, 1, '0, "R8");
        // R6: fill all slots, wrap, then reset; first pop reads slot 7.
        for (int i = 0; i < 10; i++) step(1, 0, AW'(13'h0800 + i * 3), "R6");
        do_reset();
        step(0, 1, '0, "R6");
        step(1, 0, 13'h0F0F, "R6");
        step(0, 1, '0, "R6");
        step(0, 1, '0, "R5");
        idle(2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule